// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block decides who goes first when both sides of a dual-port memory touch the same word at once. Each port presents a chip enable and an address. When both ports are enabled and their addresses are equal, the block keeps access for the port that was there first. It pulls an active-low busy flag low toward the other port. That flag stalls the late requester and blocks its writes until the contention ends.

Arrival order is judged once per clock. A port whose enable and address were unchanged since the previous edge is the incumbent. A port that joins the match on this edge is the newcomer and loses. When both ports join on the same edge, an alternating preference bit picks the winner, so neither side is starved.

A wide word is built from several memory slices. A single decision serves all of them: every slice gets an identical copy of both busy flags, and has its own gated write strobes. No slice can disagree with another, so the case where each port is locked out by a different slice cannot happen.

Top module: `busy_arbiter`

## Requirements
- R1: When either enable is low, or the two addresses differ, at a clock edge, every busy output is high after that edge.
- R2: When the match first appears, the port whose enable and address were unchanged since the previous edge wins. The other port's busy goes low after that same edge.
- R3: The left and right busy outputs are never low at the same time.
- R4: When both ports join a match on the same edge, exactly one side gets busy. The first such tie after reset makes right busy. Each further tie flips the choice.
- R5: A write request from the losing port produces no write strobe. This holds from the cycle in which contention is first seen, and for as long as the contention lasts. A write request from the winning port, or from a port with no contention, passes through unchanged.
- R6: While the match persists, the decision holds. Busy returns high on the edge after the match ends, whether the match ends through an address change or an enable dropping.
- R7: A contention can start from enable timing alone. If the addresses are already equal and one port's enable rises later, that port loses.
- R8: A contention can start from an address change alone. If both ports are enabled and one port moves onto the other's address, the moving port loses.
- R9: All slices receive identical busy values on every cycle.
- R10: After reset, all busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_l | input | 1 | Left port enable, active high |
| addr_l | input | ADDR_W | Left port word address |
| en_r | input | 1 | Right port enable, active high |
| addr_r | input | ADDR_W | Right port word address |
| wr_req_l | input | SLICES | Left write request, one bit per slice |
| wr_req_r | input | SLICES | Right write request, one bit per slice |
| busy_l_n | output | SLICES | Left busy, active low, one copy per slice |
| busy_r_n | output | SLICES | Right busy, active low, one copy per slice |
| wr_go_l | output | SLICES | Left write strobe after contention gating |
| wr_go_r | output | SLICES | Right write strobe after contention gating |

## Verification
The busy flags come from a register. A busy change caused by inputs present at an edge is therefore visible one cycle later, right after that edge. The bench drives inputs one time unit after a rising edge and reads busy one time unit after the next rising edge.

The write strobes are combinational from the current inputs and the pending decision. The bench therefore reads them in the same cycle, before the edge. This shows that a newcomer's write is blocked in the very cycle of its arrival.

An exhaustive sweep over every address pair and enable pair of a 3-bit configuration checks that busy appears one edge after the second arrival and holds through the following edge. Directed sequences cover ties, address-triggered contention and release timing.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_LEFT_OWNS  = 2'd1,
    ST_RIGHT_OWNS = 2'd2
  } own_e;
endpackage

// File: rtl/match_watch.sv
module match_watch #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              match,
  output logic              stable_l,
  output logic              stable_r
);
  logic              en_l_q, en_r_q;
  logic [ADDR_W-1:0] addr_l_q, addr_r_q;

  // Previous-edge copies let the FSM tell an incumbent from a newcomer.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_l_q   <= 1'b0;
      en_r_q   <= 1'b0;
      addr_l_q <= '0;
      addr_r_q <= '0;
    end else begin
      en_l_q   <= en_l;
      en_r_q   <= en_r;
      addr_l_q <= addr_l;
      addr_r_q <= addr_r;
    end
  end

  assign match    = en_l && en_r && (addr_l == addr_r);
  assign stable_l = en_l_q && (addr_l_q == addr_l);
  assign stable_r = en_r_q && (addr_r_q == addr_r);
endmodule

// File: rtl/own_fsm.sv
module own_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic stable_l,
  input  logic stable_r,
  output own_e state_q,
  output own_e state_d
);
  logic tie_pref_q;   // 0: left wins next tie, 1: right wins
  logic tie_hit;

  always_comb begin
    state_d = state_q;
    tie_hit = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (match) begin
          if (stable_l && !stable_r)      state_d = ST_LEFT_OWNS;
          else if (stable_r && !stable_l) state_d = ST_RIGHT_OWNS;
          else begin
            state_d = tie_pref_q ? ST_RIGHT_OWNS : ST_LEFT_OWNS;
            tie_hit = 1'b1;
          end
        end
      end
      default: begin
        if (!match) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tie_pref_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tie_hit) tie_pref_q <= ~tie_pref_q;
    end
  end

  // R6: an owned state survives as long as the match survives
  assert_hold_decision_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && match) |=> $stable(state_q));

  // R2: a lone incumbent on the left is granted ownership
  assert_incumbent_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && match && stable_l && !stable_r) |=> (state_q == ST_LEFT_OWNS));

  // R4: a tie always produces some owner
  assert_tie_resolves_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && match) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/write_gate.sv
module write_gate
  import arb_pkg::*;
#(
  parameter int SLICES = 2
) (
  input  own_e              state_d,
  input  logic [SLICES-1:0] wr_req_l,
  input  logic [SLICES-1:0] wr_req_r,
  output logic [SLICES-1:0] wr_go_l,
  output logic [SLICES-1:0] wr_go_r
);
  logic block_l, block_r;

  // The pending decision is used, so a newcomer is blocked on arrival.
  assign block_l = (state_d == ST_RIGHT_OWNS);
  assign block_r = (state_d == ST_LEFT_OWNS);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign wr_go_l[s] = wr_req_l[s] && !block_l;
    assign wr_go_r[s] = wr_req_r[s] && !block_r;
  end
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SLICES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [SLICES-1:0] wr_req_l,
  input  logic [SLICES-1:0] wr_req_r,
  output logic [SLICES-1:0] busy_l_n,
  output logic [SLICES-1:0] busy_r_n,
  output logic [SLICES-1:0] wr_go_l,
  output logic [SLICES-1:0] wr_go_r
);
  localparam logic [SLICES-1:0] ALL_HIGH = {SLICES{1'b1}};

  logic match, stable_l, stable_r;
  own_e state_q, state_d;

  match_watch #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst),
    .en_l(en_l), .addr_l(addr_l), .en_r(en_r), .addr_r(addr_r),
    .match(match), .stable_l(stable_l), .stable_r(stable_r)
  );

  own_fsm u_fsm (
    .clk(clk), .rst(rst),
    .match(match), .stable_l(stable_l), .stable_r(stable_r),
    .state_q(state_q), .state_d(state_d)
  );

  write_gate #(.SLICES(SLICES)) u_gate (
    .state_d(state_d),
    .wr_req_l(wr_req_l), .wr_req_r(wr_req_r),
    .wr_go_l(wr_go_l), .wr_go_r(wr_go_r)
  );

  // One registered decision fans out to every slice.
  for (genvar s = 0; s < SLICES; s++) begin : g_fan
    assign busy_l_n[s] = (state_q != ST_RIGHT_OWNS);
    assign busy_r_n[s] = (state_q != ST_LEFT_OWNS);
  end

  // R1: no match at an edge means every flag is released after it
  assert_no_match_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !match |=> (busy_l_n == ALL_HIGH && busy_r_n == ALL_HIGH));

  // R3: never both sides busy
  assert_one_side_R3: assert property (@(posedge clk) disable iff (rst)
    !(!busy_l_n[0] && !busy_r_n[0]));

  // R5: an ongoing contention keeps the busy side's writes blocked
  assert_block_loser_R5: assert property (@(posedge clk) disable iff (rst)
    (match && !busy_r_n[0]) |-> (wr_go_r == '0));

  // R9: every slice shows the same flags
  assert_slices_agree_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_l_n == {SLICES{busy_l_n[0]}}) && (busy_r_n == {SLICES{busy_r_n[0]}}));
endmodule

// File: tb/busy_arbiter_bench.sv
module busy_arbiter_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 3;
  localparam int SLICES = 2;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst;
  logic en_l, en_r;
  logic [ADDR_W-1:0] addr_l, addr_r;
  logic [SLICES-1:0] wr_req_l, wr_req_r;
  logic [SLICES-1:0] busy_l_n, busy_r_n, wr_go_l, wr_go_r;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  busy_arbiter #(.ADDR_W(ADDR_W), .SLICES(SLICES)) u_busy_arbiter (
    .clk(clk), .rst(rst),
    .en_l(en_l), .addr_l(addr_l), .en_r(en_r), .addr_r(addr_r),
    .wr_req_l(wr_req_l), .wr_req_r(wr_req_r),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .wr_go_l(wr_go_l), .wr_go_r(wr_go_r)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // advance to just after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // busy pattern as {left,right}, replicated check for all slices
  task automatic chk_busy(input string req, input logic exp_l, input logic exp_r);
    chk(req, {6'd0, busy_l_n[0], busy_r_n[0]}, {6'd0, exp_l, exp_r});
    chk({req, " R9"}, {6'd0, busy_l_n == {SLICES{busy_l_n[0]}}, busy_r_n == {SLICES{busy_r_n[0]}}}, 8'h3);
  endtask

  task automatic idle();
    en_l = 1'b0; en_r = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en_l = 1'b0; en_r = 1'b0;
    addr_l = '0; addr_r = '0; wr_req_l = '0; wr_req_r = '0;
    step(); step();
    rst = 1'b0;
    chk_busy("R10 reset", 1'b1, 1'b1);

    // Exhaustive: left settles first, right joins one edge later.
    for (int a = 0; a < NADDR; a++) begin
      for (int b = 0; b < NADDR; b++) begin
        for (int e = 0; e < 4; e++) begin
          logic hit;
          idle();
          en_l = e[0]; addr_l = a[ADDR_W-1:0];
          step();
          en_r = e[1]; addr_r = b[ADDR_W-1:0];
          wr_req_l = '1; wr_req_r = '1;
          hit = e[0] && e[1] && (a == b);
          #1;
          chk("R5 newcomer write same cycle", {6'd0, wr_go_l[0], wr_go_r[1]}, {6'd0, 1'b1, !hit});
          step();
          if (hit) chk_busy("R2 late right loses", 1'b1, 1'b0);
          else     chk_busy("R1 no contention", 1'b1, 1'b1);
          step();
          chk_busy("R6 held", 1'b1, !hit);
          wr_req_l = '0; wr_req_r = '0;
        end
      end
    end

    // R7: addresses already equal, left enable arrives later -> left loses
    idle();
    addr_l = 3'd5; addr_r = 3'd5; en_r = 1'b1;
    step();
    en_l = 1'b1; wr_req_l = 2'b11;
    #1;
    chk("R7 late enable write blocked", {6'd0, wr_go_l}, 8'h0);
    step();
    chk_busy("R7 late enable loses", 1'b0, 1'b1);
    chk("R5 loser write blocked while busy", {6'd0, wr_go_l}, 8'h0);
    // R6: enable drop releases one edge later
    en_r = 1'b0;
    #1;
    chk("R5 write passes once match gone", {6'd0, wr_go_l}, 8'h3);
    chk_busy("R6 still busy before edge", 1'b0, 1'b1);
    step();
    chk_busy("R6 release on enable drop", 1'b1, 1'b1);
    wr_req_l = '0;

    // R8: both enabled apart, right moves onto left address -> right loses
    idle();
    en_l = 1'b1; en_r = 1'b1; addr_l = 3'd2; addr_r = 3'd6;
    step();
    step();
    chk_busy("R8 apart", 1'b1, 1'b1);
    addr_r = 3'd2;
    step();
    chk_busy("R8 moving port loses", 1'b1, 1'b0);
    // left moves away: release
    addr_l = 3'd3;
    step();
    chk_busy("R6 release on address change", 1'b1, 1'b1);
    // left comes back: now right is incumbent, left loses
    addr_l = 3'd2;
    step();
    chk_busy("R8 returning port loses", 1'b0, 1'b1);

    // R4: ties alternate, first after reset makes right busy
    idle();
    idle();
    addr_l = 3'd7; addr_r = 3'd7; en_l = 1'b1; en_r = 1'b1;
    step();
    chk_busy("R4 first tie", 1'b1, 1'b0);
    idle();
    chk_busy("R1 after tie", 1'b1, 1'b1);
    en_l = 1'b1; en_r = 1'b1; addr_l = 3'd1; addr_r = 3'd1;
    wr_req_l = 2'b01; wr_req_r = 2'b10;
    #1;
    chk("R5 tie loser blocked", {4'd0, wr_go_l, wr_go_r}, {4'd0, 2'b00, 2'b10});
    step();
    chk_busy("R4 second tie", 1'b0, 1'b1);
    wr_req_l = '0; wr_req_r = '0;
    idle();
    en_l = 1'b1; en_r = 1'b1;
    step();
    chk_busy("R4 third tie", 1'b1, 1'b0);
    step();
    chk_busy("R3 one side only", 1'b1, 1'b0);

    // R10: reset clears a held decision
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk_busy("R10 reset mid-contention", 1'b1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule